// File: doc/BRIEF.md
# Double-Buffered Backlight Dimming PWM

This block produces one active-high pulse train for dimming a display backlight. A 10-bit prescaler divides the input clock, a 12-bit counter steps through each output period and a 13-bit compare value sets how long the pulse stays high at the start of every period. Software programs the block through a small word-addressed register port, with write and read strobes and a read result that arrives one cycle after the read strobe.

The divider, period and high-width values are written into shadow registers first. A commit handshake snapshots the shadow set. The snapshot then moves into the working set that drives the counters at the next period boundary, so the pulse that is already running is never cut short. If the mode field selects direct operation, the working set follows the shadow set one cycle after each write, with no commit needed. While the enable bit is clear, the output is held low and both counters are held at zero.

Top module: `bl_pwm_top`

## Requirements
- R1: After synchronous reset, `pwm_out` is low and every register reads as zero.
- R2: With the block enabled, one output period lasts (divider + 1) × (period + 1) clock cycles. The divider is in word 2, bits [25:16]. The period is in word 3, bits [11:0].
- R3: Each period starts with a high phase of (divider + 1) × high_width cycles. The high width is in word 3, bits [28:16]. The output is low for the rest of the period.
- R4: If high_width is greater than or equal to period + 1, the output stays high for the whole period. If high_width is 0, the output stays low.
- R5: The enable bit is word 0, bit 0. While it is 0, the output is low. When it rises, both the prescaler and the period counter start again from zero.
- R6: A shadow write has no effect on the output until a commit. A commit is a write of 1 to word 1, bit 0, followed by a write of 0 to the same bit.
- R7: A commit that arrives while the block is enabled reaches the output at the next period boundary. A commit that arrives while the block is disabled loads the working set at once.
- R8: When the mode field (word 4, bits [1:0]) equals 2'b11, shadow writes reach the working set on the next cycle without a commit. Any other value of the field keeps double buffering.
- R9: A read returns the shadow contents of the addressed word on the cycle after the read strobe. Reads are zero when no read is strobed.
- R10: Bits outside the defined fields are not stored and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Backlight pulse output |

## Verification
The risky overlap is a commit strobe that falls in the same cycle as a period boundary at which an older commit is still waiting. In that case the older snapshot must load while the newer snapshot is captured and held for the following boundary. The bench shortens the period to four cycles and then issues commit handshakes with gaps of zero to seven idle cycles, so every phase of the counter meets a commit edge. A behavioural model tracks pending state, snapshot and working values independently and compares the output and read data on every clock.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int DIV_W   = 10;
  localparam int PER_W   = 12;
  localparam int HI_W    = 13;
  localparam int DIV_LSB = 16;
  localparam int PER_LSB = 0;
  localparam int HI_LSB  = 16;
  localparam int MODE_W  = 2;
  localparam int REG_AW  = 3;

  localparam logic [REG_AW-1:0] A_ENABLE = 3'd0;
  localparam logic [REG_AW-1:0] A_COMMIT = 3'd1;
  localparam logic [REG_AW-1:0] A_CLKCTL = 3'd2;
  localparam logic [REG_AW-1:0] A_SHAPE  = 3'd3;
  localparam logic [REG_AW-1:0] A_MODE   = 3'd4;

  localparam logic [MODE_W-1:0] MODE_DIRECT = 2'b11;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [HI_W-1:0]  hi;
  } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output pwm_cfg_t            shadow_o,
  output logic                enable_o,
  output logic                direct_o,
  output logic                commit_stb_o
);
  localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

  logic              en_q;
  logic              commit_q;
  logic [MODE_W-1:0] mode_q;
  pwm_cfg_t          shadow_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_ENABLE: rd_mux[0] = en_q;
      A_COMMIT: rd_mux[0] = commit_q;
      A_CLKCTL: rd_mux[DIV_LSB +: DIV_W] = shadow_q.div;
      A_SHAPE: begin
        rd_mux[PER_LSB +: PER_W] = shadow_q.per;
        rd_mux[HI_LSB +: HI_W]   = shadow_q.hi;
      end
      A_MODE:   rd_mux[MODE_W-1:0] = mode_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q         <= 1'b0;
      commit_q     <= 1'b0;
      mode_q       <= '0;
      shadow_q     <= '0;
      commit_stb_o <= 1'b0;
      rdata_o      <= '0;
    end else begin
      commit_stb_o <= 1'b0;
      rdata_o      <= rd_i ? rd_mux : '0;
      if (wr_i) begin
        unique case (addr_i)
          A_ENABLE: en_q <= wdata_i[0];
          A_COMMIT: begin
            commit_q     <= wdata_i[0];
            commit_stb_o <= commit_q & ~wdata_i[0];
          end
          A_CLKCTL: shadow_q.div <= wdata_i[DIV_LSB +: DIV_W];
          A_SHAPE: begin
            shadow_q.per <= wdata_i[PER_LSB +: PER_W];
            shadow_q.hi  <= wdata_i[HI_LSB +: HI_W];
          end
          A_MODE:   mode_q <= wdata_i[MODE_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign shadow_o = shadow_q;
  assign enable_o = en_q;
  assign direct_o = (mode_q == MODE_DIRECT);

  AST_COMMIT_AFTER_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    commit_stb_o |-> (!commit_q && $past(commit_q))); // R6
  AST_CLKCTL_PAD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && addr_i == A_CLKCTL) |=> (rdata_o[DATA_W-1:DIV_MSB+1] == '0 && rdata_o[DIV_LSB-1:0] == '0)); // R10
  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_i |=> (rdata_o == '0)); // R9
endmodule

// File: rtl/bl_pwm_bank.sv
module bl_pwm_bank
  import bl_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  pwm_cfg_t shadow_i,
  input  logic     commit_stb_i,
  input  logic     direct_i,
  input  logic     enable_i,
  input  logic     boundary_i,
  output pwm_cfg_t work_o
);
  pwm_cfg_t staged_q;
  pwm_cfg_t work_q;
  logic     pend_q;
  logic     load_now;

  assign load_now = pend_q & (boundary_i | ~enable_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      staged_q <= '0;
      work_q   <= '0;
      pend_q   <= 1'b0;
    end else if (direct_i) begin
      work_q <= shadow_i;
      pend_q <= 1'b0;
    end else begin
      if (load_now) begin
        work_q <= staged_q;
        pend_q <= 1'b0;
      end
      if (commit_stb_i) begin
        staged_q <= shadow_i;
        pend_q   <= 1'b1;
      end
    end
  end

  assign work_o = work_q;

  AST_PEND_DRAINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_q && !commit_stb_i && !direct_i && (boundary_i || !enable_i)) |=> !pend_q); // R7
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!direct_i && !pend_q) |=> $stable(work_q)); // R6
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     enable_i,
  input  pwm_cfg_t cfg_i,
  output logic     boundary_o,
  output logic     pwm_o
);
  logic [DIV_W-1:0] pre_q;
  logic [PER_W-1:0] cnt_q;
  logic             pre_end;
  logic             cnt_end;
  logic             high_now;

  assign pre_end    = (pre_q >= cfg_i.div);
  assign cnt_end    = (cnt_q >= cfg_i.per);
  assign boundary_o = enable_i & pre_end & cnt_end;
  assign high_now   = ({{(HI_W-PER_W){1'b0}}, cnt_q} < cfg_i.hi);

  always_ff @(posedge clk_i) begin
    if (rst_i || !enable_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_end) begin
      pre_q <= '0;
      cnt_q <= cnt_end ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) pwm_o <= 1'b0;
    else       pwm_o <= enable_i & high_now;
  end

  AST_OFF_IS_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    !enable_i |=> !pwm_o); // R5
  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(enable_i) |-> (pre_q == '0 && cnt_q == '0)); // R5
  AST_ZERO_WIDTH_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (enable_i && cfg_i.hi == '0) |=> !pwm_o); // R4
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  pwm_cfg_t shadow;
  pwm_cfg_t work;
  logic     enable;
  logic     direct;
  logic     commit_stb;
  logic     boundary;

  bl_pwm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk), .rst_i(rst), .wr_i(bus_wr), .rd_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .shadow_o(shadow), .enable_o(enable), .direct_o(direct),
    .commit_stb_o(commit_stb)
  );

  bl_pwm_bank u_bank (
    .clk_i(clk), .rst_i(rst), .shadow_i(shadow), .commit_stb_i(commit_stb),
    .direct_i(direct), .enable_i(enable), .boundary_i(boundary), .work_o(work)
  );

  bl_pwm_core u_core (
    .clk_i(clk), .rst_i(rst), .enable_i(enable), .cfg_i(work),
    .boundary_o(boundary), .pwm_o(pwm_out)
  );
endmodule

// File: tb/sim_bl_pwm_top.sv
module sim_bl_pwm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_wr = 1'b0;
  logic        b_rd = 1'b0;
  logic [2:0]  b_addr = 3'd0;
  logic [31:0] b_wd = 32'd0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  bl_pwm_top u0 (
    .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wd), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // behavioural reference state
  int m_en, m_cq, m_cstb, m_mode, m_pend, m_pre, m_cnt;
  int s_div, s_per, s_hi, st_div, st_per, st_hi, w_div, w_per, w_hi;
  logic        m_out;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    logic [31:0] v;
    v = 32'd0;
    case (a)
      3'd0: v[0] = (m_en != 0);
      3'd1: v[0] = (m_cq != 0);
      3'd2: v[25:16] = 10'(s_div);
      3'd3: begin v[11:0] = 12'(s_per); v[28:16] = 13'(s_hi); end
      3'd4: v[1:0] = 2'(m_mode);
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    int npre, ncnt, ncstb;
    logic bnd, nout;
    if (rst) begin
      m_en = 0; m_cq = 0; m_cstb = 0; m_mode = 0; m_pend = 0; m_pre = 0; m_cnt = 0;
      s_div = 0; s_per = 0; s_hi = 0; st_div = 0; st_per = 0; st_hi = 0;
      w_div = 0; w_per = 0; w_hi = 0; m_out = 1'b0; m_rdata = 32'd0;
    end else begin
      bnd  = (m_en != 0) && m_pre >= w_div && m_cnt >= w_per;
      nout = (m_en != 0) && (m_cnt < w_hi);
      if (m_en == 0) begin npre = 0; ncnt = 0; end
      else if (m_pre >= w_div) begin npre = 0; ncnt = (m_cnt >= w_per) ? 0 : m_cnt + 1; end
      else begin npre = m_pre + 1; ncnt = m_cnt; end
      if (m_mode == 3) begin
        w_div = s_div; w_per = s_per; w_hi = s_hi; m_pend = 0;
      end else begin
        if (m_pend != 0 && (bnd || m_en == 0)) begin
          w_div = st_div; w_per = st_per; w_hi = st_hi; m_pend = 0;
        end
        if (m_cstb != 0) begin
          st_div = s_div; st_per = s_per; st_hi = s_hi; m_pend = 1;
        end
      end
      m_rdata = b_rd ? model_read(b_addr) : 32'd0;
      ncstb = 0;
      if (b_wr) begin
        case (b_addr)
          3'd0: m_en = int'(b_wd[0]);
          3'd1: begin ncstb = (m_cq != 0 && !b_wd[0]) ? 1 : 0; m_cq = int'(b_wd[0]); end
          3'd2: s_div = int'(b_wd[25:16]);
          3'd3: begin s_per = int'(b_wd[11:0]); s_hi = int'(b_wd[28:16]); end
          3'd4: m_mode = int'(b_wd[1:0]);
          default: ;
        endcase
      end
      m_cstb = ncstb; m_pre = npre; m_cnt = ncnt; m_out = nout;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (pwm_out !== m_out || bus_rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s cycle %0d: pwm_out=%b rdata=%h expected pwm_out=%b rdata=%h",
                 cur_req, cyc, pwm_out, bus_rdata, m_out, m_rdata);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); b_wr = 1'b1; b_addr = a; b_wd = d;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); b_rd = 1'b1; b_addr = a;
    @(negedge clk); b_rd = 1'b0;
    n_cmp++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read word %0d: actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic commit();
    wreg(3'd1, 32'd1);
    wreg(3'd1, 32'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] shape(input int per, input int hi);
    return {3'b000, 13'(hi), 4'b0000, 12'(per)};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    for (int a = 0; a < 5; a++) rchk(3'(a), 32'd0, "R1");
    n_cmp++;
    if (pwm_out !== 1'b0) begin
      n_bad++; $display("FAIL R1 pwm_out actual %b expected 0", pwm_out);
    end
    // R10 / R9: field positions and read-back of shadow contents
    cur_req = "R10";
    wreg(3'd2, 32'hFFFF_FFFF); rchk(3'd2, 32'h03FF_0000, "R10");
    wreg(3'd3, 32'hFFFF_FFFF); rchk(3'd3, 32'h1FFF_0FFF, "R10");
    wreg(3'd4, 32'hFFFF_FFFD); rchk(3'd4, 32'h0000_0001, "R10");
    wreg(3'd0, 32'hFFFF_FFFE); rchk(3'd0, 32'h0000_0000, "R10");
    cur_req = "R9";
    wreg(3'd4, 32'd0);
    wreg(3'd2, 32'd2 << 16); rchk(3'd2, 32'h0002_0000, "R9");
    wreg(3'd3, shape(9, 4)); rchk(3'd3, 32'h0004_0009, "R9");
    wreg(3'd1, 32'd1); rchk(3'd1, 32'd1, "R9");
    wreg(3'd1, 32'd0);
    // R2 / R3: basic waveform, commit while disabled loads at once (R7)
    cur_req = "R2";
    wreg(3'd0, 32'd1); idle(200);
    cur_req = "R3";
    wreg(3'd2, 32'd0); wreg(3'd3, shape(6, 2)); commit(); idle(120);
    // R6: shadow change without commit does nothing
    cur_req = "R6";
    wreg(3'd3, shape(3, 1)); wreg(3'd2, 32'd5 << 16); idle(100);
    wreg(3'd1, 32'd1); idle(60);
    // R7: commit lands at a period boundary
    cur_req = "R7";
    wreg(3'd1, 32'd0); idle(150);
    wreg(3'd2, 32'd1 << 16); wreg(3'd3, shape(11, 7)); commit(); idle(100);
    // R4: full-high and zero-width
    cur_req = "R4";
    wreg(3'd3, shape(9, 20)); commit(); idle(100);
    wreg(3'd3, shape(9, 10)); commit(); idle(80);
    wreg(3'd3, shape(9, 0)); commit(); idle(80);
    // R5: enable gating and restart
    cur_req = "R5";
    wreg(3'd3, shape(5, 3)); commit(); idle(40);
    wreg(3'd0, 32'd0); idle(30);
    wreg(3'd0, 32'd1); idle(13);
    wreg(3'd0, 32'd0); wreg(3'd0, 32'd1); idle(60);
    // R8: mode 01 keeps double buffering, 11 acts directly
    cur_req = "R8";
    wreg(3'd4, 32'd1); wreg(3'd3, shape(4, 2)); idle(60);
    wreg(3'd4, 32'd3); idle(40);
    wreg(3'd3, shape(2, 1)); idle(30);
    wreg(3'd2, 32'd0); wreg(3'd3, shape(7, 5)); idle(40);
    wreg(3'd4, 32'd0); wreg(3'd3, shape(3, 2)); idle(40);
    // R7: commit edges across every counter phase, boundary collisions
    cur_req = "R7";
    commit(); idle(20);
    for (int k = 0; k < 8; k++) begin
      wreg(3'd3, shape(3, (k % 4) + 1));
      wreg(3'd1, 32'd1);
      idle(k);
      wreg(3'd1, 32'd0);
      wreg(3'd3, shape(3, ((k + 2) % 4) + 1));
      commit();
      idle(3);
    end
    idle(40);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule